// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a shared memory port and decides whether store-exclusive operations issued by several processors may write memory. Every processor presents requests on its own lane. A request carries a kind (load-exclusive, store-exclusive, ordinary store or clear), a physical address, an access size and a shared-attribute bit. A fixed-priority arbiter accepts one request per cycle. The accepted request updates the reservation state of its processor. One cycle later the block reports a response with a status bit and a memory write enable.

Two reservation kinds live side by side for each processor. A load-exclusive with the shared bit set records an 8-byte address granule. A load-exclusive without the shared bit records only an "exclusive outstanding" flag. Each later store-exclusive is judged by the check that its own shared bit selects. The granule of the latest load-exclusive is kept in every case, so a store-exclusive aimed at a different granule always fails. A successful store-exclusive or an ordinary store to a shared granule takes away any reservation that other processors hold on that granule. This is how a competing processor gets locked out.

Top module: `excl_monitor`

## Requirements
- R1: A load-exclusive with the shared bit set records the request's granule as reserved for that processor and clears that processor's outstanding flag. The new reservation replaces any earlier one. Kind codes: 0 load-exclusive, 1 store-exclusive, 2 ordinary store, 3 clear.
- R2: A load-exclusive with the shared bit clear sets the processor's outstanding flag and drops its shared reservation. Its granule is kept only for the mismatch check of R6.
- R3: A store-exclusive with the shared bit clear succeeds only if the processor's outstanding flag is set and its granule equals that of the processor's latest load-exclusive.
- R4: A store-exclusive with the shared bit set succeeds only if the processor holds a shared reservation on exactly the request's granule.
- R5: The response status is 0 when the store was performed and 1 when it was locked out. Write enable is 1 for a successful store-exclusive and for every ordinary store, and 0 otherwise. Load-exclusive and clear answer status 0.
- R6: Every store-exclusive, whether it succeeds or fails, removes the requester's shared reservation and its outstanding flag. A store-exclusive to a granule other than the one of the latest load-exclusive therefore fails and leaves nothing behind.
- R7: Addresses are compared by granule, which is address bit 3 and above. Size codes 0 byte, 1 halfword, 2 word and 3 doubleword are all accepted, and the address and size are passed through to the response.
- R8: A successful store-exclusive or an ordinary store with the shared bit set removes the shared reservations that other processors hold on the same granule. An ordinary store with the shared bit clear changes no reservation.
- R9: Reset, or a clear request from a processor, removes that processor's shared reservation and its outstanding flag.
- R10: The grant is combinational and goes to the lowest-numbered requesting processor. The response (valid, processor ID, kind, address, size, status, write enable) appears one cycle after the grant. A cycle with no request gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_CPU | Request present, one bit per processor, held until granted |
| req_kind | input | 2*N_CPU | Request kind per processor (0 ld-excl, 1 st-excl, 2 store, 3 clear) |
| req_addr | input | ADDR_W*N_CPU | Physical address per processor |
| req_size | input | 2*N_CPU | Access size per processor (0 byte .. 3 doubleword) |
| req_shared | input | N_CPU | Shared attribute per processor |
| grant | output | N_CPU | One-hot acceptance of this cycle's request |
| resp_valid | output | 1 | Response present |
| resp_id | output | IDW | Processor the response belongs to |
| resp_kind | output | 2 | Kind of the answered request |
| resp_addr | output | ADDR_W | Address of the answered request |
| resp_size | output | 2 | Size of the answered request |
| resp_status | output | 1 | 0 performed, 1 locked out |
| resp_wr_en | output | 1 | Memory write enable |

## Verification
On every cycle the assertions check the arbiter: the grant is one-hot, it only covers requesting lanes, and it is never empty while a request waits. They also check that the response follows the grant by one cycle for the granted processor, that a locked-out status never comes with a write enable, and that after a store-exclusive or a clear the processor holds nothing. Whether a store succeeds depends on the history of loads, stores and clears across processors. This covers competitors taking away reservations, the granule match across sizes, the mismatch rule and reset in mid-sequence. Only the bench's directed and random scenarios, compared against its own reference model, can show these.

// File: rtl/excl_pkg.sv
package excl_pkg;

    typedef enum logic [1:0] {
        OP_LDX   = 2'd0,
        OP_STX   = 2'd1,
        OP_STORE = 2'd2,
        OP_CLR   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    function automatic logic op_is_write(op_e k);
        return (k == OP_STX) || (k == OP_STORE);
    endfunction

endpackage

// File: rtl/excl_prio_arb.sv
module excl_prio_arb #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic [N-1:0]   req,
    output logic [N-1:0]   gnt,
    output logic [IDW-1:0] gnt_id,
    output logic           gnt_any
);
    always_comb begin
        gnt     = '0;
        gnt_id  = '0;
        gnt_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt     = '0;
                gnt[i]  = 1'b1;
                gnt_id  = IDW'(i);
                gnt_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/excl_slot.sv
module excl_slot #(
    parameter int GW = 29
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ldx,
    input  logic          ldx_shared,
    input  logic [GW-1:0] gran,
    input  logic          drop,
    input  logic          kill,
    output logic          sh_res,
    output logic          nsh_flag,
    output logic [GW-1:0] last_gran
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_res    <= 1'b0;
            nsh_flag  <= 1'b0;
            last_gran <= '0;
        end else if (ldx) begin
            last_gran <= gran;
            sh_res    <= ldx_shared;
            nsh_flag  <= !ldx_shared;
        end else if (drop) begin
            sh_res    <= 1'b0;
            nsh_flag  <= 1'b0;
        end else if (kill) begin
            sh_res    <= 1'b0;
        end
    end
endmodule

// File: rtl/excl_judge.sv
module excl_judge
    import excl_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = 2,
    parameter int GW  = 29
) (
    input  logic                  win_any,
    input  logic [IDW-1:0]        win_id,
    input  op_e                   kind,
    input  logic [GW-1:0]         gran,
    input  logic                  shared,
    input  logic [N-1:0]          sh_v,
    input  logic [N-1:0]          nsh_v,
    input  logic [N-1:0][GW-1:0]  last_v,
    output logic                  status,
    output logic                  wr_en,
    output logic [N-1:0]          ldx_v,
    output logic [N-1:0]          drop_v,
    output logic [N-1:0]          kill_v
);
    logic own_hit;
    logic snoop;
    logic pass;

    always_comb begin
        own_hit = (last_v[win_id] == gran);
        pass    = own_hit && (shared ? sh_v[win_id] : nsh_v[win_id]);
        status  = 1'b0;
        wr_en   = 1'b0;
        snoop   = 1'b0;
        ldx_v   = '0;
        drop_v  = '0;
        if (win_any) begin
            unique case (kind)
                OP_LDX: ldx_v[win_id] = 1'b1;
                OP_STX: begin
                    status         = !pass;
                    wr_en          = pass;
                    drop_v[win_id] = 1'b1;
                    snoop          = pass && shared;
                end
                OP_STORE: begin
                    wr_en = 1'b1;
                    snoop = shared;
                end
                OP_CLR: drop_v[win_id] = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        for (int c = 0; c < N; c++) begin
            kill_v[c] = snoop && (c != int'(win_id)) && sh_v[c] && (last_v[c] == gran);
        end
    end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_pkg::*;
#(
    parameter int N_CPU   = 4,
    parameter int ADDR_W  = 32,
    parameter int GRAN_LG = 3,
    localparam int IDW    = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_CPU-1:0]        req_valid,
    input  logic [2*N_CPU-1:0]      req_kind,
    input  logic [ADDR_W*N_CPU-1:0] req_addr,
    input  logic [2*N_CPU-1:0]      req_size,
    input  logic [N_CPU-1:0]        req_shared,
    output logic [N_CPU-1:0]        grant,
    output logic                    resp_valid,
    output logic [IDW-1:0]          resp_id,
    output logic [1:0]              resp_kind,
    output logic [ADDR_W-1:0]       resp_addr,
    output logic [1:0]              resp_size,
    output logic                    resp_status,
    output logic                    resp_wr_en
);
    localparam int GW = ADDR_W - GRAN_LG;

    logic [IDW-1:0]            win_id;
    logic                      win_any;
    op_e                       sel_kind;
    logic [ADDR_W-1:0]         sel_addr;
    logic [1:0]                sel_size;
    logic                      sel_shared;
    logic [GW-1:0]             sel_gran;

    logic [N_CPU-1:0]          sh_v;
    logic [N_CPU-1:0]          nsh_v;
    logic [N_CPU-1:0][GW-1:0]  last_v;
    logic [N_CPU-1:0]          ldx_v;
    logic [N_CPU-1:0]          drop_v;
    logic [N_CPU-1:0]          kill_v;
    logic                      jd_status;
    logic                      jd_wr_en;

    excl_prio_arb #(.N(N_CPU), .IDW(IDW)) u_arb (
        .req     (req_valid),
        .gnt     (grant),
        .gnt_id  (win_id),
        .gnt_any (win_any)
    );

    always_comb begin
        sel_kind   = op_e'(req_kind[win_id*2 +: 2]);
        sel_addr   = req_addr[win_id*ADDR_W +: ADDR_W];
        sel_size   = req_size[win_id*2 +: 2];
        sel_shared = req_shared[win_id];
        sel_gran   = sel_addr[ADDR_W-1:GRAN_LG];
    end

    for (genvar g = 0; g < N_CPU; g++) begin : g_slot
        excl_slot #(.GW(GW)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .ldx        (ldx_v[g]),
            .ldx_shared (sel_shared),
            .gran       (sel_gran),
            .drop       (drop_v[g]),
            .kill       (kill_v[g]),
            .sh_res     (sh_v[g]),
            .nsh_flag   (nsh_v[g]),
            .last_gran  (last_v[g])
        );
    end

    excl_judge #(.N(N_CPU), .IDW(IDW), .GW(GW)) u_judge (
        .win_any (win_any),
        .win_id  (win_id),
        .kind    (sel_kind),
        .gran    (sel_gran),
        .shared  (sel_shared),
        .sh_v    (sh_v),
        .nsh_v   (nsh_v),
        .last_v  (last_v),
        .status  (jd_status),
        .wr_en   (jd_wr_en),
        .ldx_v   (ldx_v),
        .drop_v  (drop_v),
        .kill_v  (kill_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_id     <= '0;
            resp_kind   <= OP_LDX;
            resp_addr   <= '0;
            resp_size   <= SZ_BYTE;
            resp_status <= 1'b0;
            resp_wr_en  <= 1'b0;
        end else begin
            resp_valid  <= win_any;
            resp_id     <= win_id;
            resp_kind   <= sel_kind;
            resp_addr   <= sel_addr;
            resp_size   <= sel_size;
            resp_status <= win_any && jd_status;
            resp_wr_en  <= win_any && jd_wr_en;
        end
    end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk
    import excl_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int IDW   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [N_CPU-1:0] req_valid,
    input logic [N_CPU-1:0] grant,
    input logic             resp_valid,
    input logic [IDW-1:0]   resp_id,
    input logic [1:0]       resp_kind,
    input logic             resp_status,
    input logic             resp_wr_en,
    input logic [N_CPU-1:0] sh_v,
    input logic [N_CPU-1:0] nsh_v
);
    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_in_req_R10: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req_valid) == '0);

    assert_grant_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid != '0) |-> (grant != '0));

    assert_resp_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |=> resp_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) |=> !resp_valid);

    assert_resp_owner_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ((($past(grant) >> resp_id) & 1) != 0));

    assert_locked_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        resp_status |-> (!resp_wr_en && resp_kind == OP_STX));

    assert_write_kind_R5: assert property (@(posedge clk) disable iff (rst)
        resp_wr_en |-> (resp_kind == OP_STX || resp_kind == OP_STORE));

    assert_stx_drops_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind == OP_STX) |-> (!sh_v[resp_id] && !nsh_v[resp_id]));

    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind == OP_CLR) |-> (!sh_v[resp_id] && !nsh_v[resp_id]));

    assert_ldx_one_kind_R1: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind == OP_LDX) |-> (sh_v[resp_id] != nsh_v[resp_id]));
endmodule

bind excl_monitor excl_monitor_chk #(.N_CPU(N_CPU), .IDW(IDW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .grant       (grant),
    .resp_valid  (resp_valid),
    .resp_id     (resp_id),
    .resp_kind   (resp_kind),
    .resp_status (resp_status),
    .resp_wr_en  (resp_wr_en),
    .sh_v        (sh_v),
    .nsh_v       (nsh_v)
);

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
    localparam int NC = 4;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NC-1:0]   req_valid = '0;
    logic [2*NC-1:0] req_kind = '0;
    logic [AW*NC-1:0] req_addr = '0;
    logic [2*NC-1:0] req_size = '0;
    logic [NC-1:0]   req_shared = '0;
    logic [NC-1:0]   grant;
    logic            resp_valid;
    logic [1:0]      resp_id;
    logic [1:0]      resp_kind;
    logic [AW-1:0]   resp_addr;
    logic [1:0]      resp_size;
    logic            resp_status;
    logic            resp_wr_en;

    always #2.5 clk = ~clk;

    excl_monitor #(.N_CPU(NC), .ADDR_W(AW), .GRAN_LG(3)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_size(req_size), .req_shared(req_shared),
        .grant(grant), .resp_valid(resp_valid), .resp_id(resp_id),
        .resp_kind(resp_kind), .resp_addr(resp_addr), .resp_size(resp_size),
        .resp_status(resp_status), .resp_wr_en(resp_wr_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // pending requests per processor
    bit          p_v [NC];
    logic [1:0]  p_k [NC];
    logic [31:0] p_a [NC];
    logic [1:0]  p_s [NC];
    bit          p_sh [NC];

    // reference model
    bit          m_sh [NC];
    bit          m_nsh [NC];
    logic [28:0] m_last [NC];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            m_sh[c] = 0; m_nsh[c] = 0; m_last[c] = '0; p_v[c] = 0;
        end
    endtask

    task automatic drive();
        for (int c = 0; c < NC; c++) begin
            req_valid[c]          = p_v[c];
            req_kind[c*2 +: 2]    = p_k[c];
            req_addr[c*AW +: AW]  = p_a[c];
            req_size[c*2 +: 2]    = p_s[c];
            req_shared[c]         = p_sh[c];
        end
    endtask

    // predicts the result of one granted request and updates the model
    task automatic predict(input int c, output bit st, output bit we);
        logic [28:0] g;
        bit ok;
        g = p_a[c][31:3];
        st = 0; we = 0;
        case (p_k[c])
            2'd0: begin m_last[c] = g; m_sh[c] = p_sh[c]; m_nsh[c] = !p_sh[c]; end
            2'd1: begin
                ok = (m_last[c] == g) && (p_sh[c] ? m_sh[c] : m_nsh[c]);
                st = !ok; we = ok;
                m_sh[c] = 0; m_nsh[c] = 0;
                if (ok && p_sh[c])
                    for (int o = 0; o < NC; o++)
                        if (o != c && m_last[o] == g) m_sh[o] = 0;
            end
            2'd2: begin
                we = 1;
                if (p_sh[c])
                    for (int o = 0; o < NC; o++)
                        if (o != c && m_last[o] == g) m_sh[o] = 0;
            end
            default: begin m_sh[c] = 0; m_nsh[c] = 0; end
        endcase
    endtask

    function automatic string tag_of(input logic [1:0] k);
        case (k)
            2'd0: return "R1";
            2'd1: return "R4";
            2'd2: return "R8";
            default: return "R9";
        endcase
    endfunction

    // one clock: check grant, predict, pass an edge, check response
    task automatic step();
        int win = -1;
        bit st, we;
        logic [31:0] ea;
        logic [1:0] ek, es;
        for (int c = NC - 1; c >= 0; c--) if (p_v[c]) win = c;
        #1;
        chk(grant == ((win >= 0) ? (NC'(1) << win) : '0), "R10 grant", grant,
            (win >= 0) ? (NC'(1) << win) : '0);
        st = 0; we = 0; ea = '0; ek = '0; es = '0;
        if (win >= 0) begin
            ea = p_a[win]; ek = p_k[win]; es = p_s[win];
            predict(win, st, we);
        end
        @(negedge clk);
        if (win < 0) begin
            chk(!resp_valid, "R10 idle", resp_valid, 0);
        end else begin
            chk(resp_valid && resp_id == 2'(win) && resp_kind == ek,
                "R10 response", {resp_valid, resp_id, resp_kind}, {1'b1, 2'(win), ek});
            chk(resp_addr == ea && resp_size == es, "R7 passthrough",
                {resp_addr, resp_size}, {ea, es});
            chk(resp_status == st && resp_wr_en == we, {tag_of(ek), " status/we"},
                {resp_status, resp_wr_en}, {st, we});
            p_v[win] = 0;
        end
        drive();
    endtask

    task automatic op(input int c, input logic [1:0] k, input logic [31:0] a, input bit sh,
                      input logic [1:0] sz, input bit exp_st, input bit exp_we, input string req);
        p_v[c] = 1; p_k[c] = k; p_a[c] = a; p_sh[c] = sh; p_s[c] = sz;
        drive();
        step();
        chk(resp_status == exp_st && resp_wr_en == exp_we, req,
            {resp_status, resp_wr_en}, {exp_st, exp_we});
    endtask

    task automatic do_reset();
        rst = 1;
        model_reset();
        drive();
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < NC; c++) begin
            p_k[c] = '0; p_a[c] = '0; p_s[c] = '0; p_sh[c] = 0;
        end
        do_reset();
        #1;
        chk(!resp_valid && grant == '0, "R9 reset state", {resp_valid, grant}, 0);

        // R9: nothing reserved after reset
        op(0, 2'd1, 32'h100, 1, 2'd2, 1, 0, "R9 stx after reset");
        // R1/R4: shared pair succeeds, then repeat fails (R6)
        op(0, 2'd0, 32'h100, 1, 2'd2, 0, 0, "R1 ldx shared");
        op(0, 2'd1, 32'h100, 1, 2'd2, 0, 1, "R4 stx shared ok");
        op(0, 2'd1, 32'h100, 1, 2'd2, 1, 0, "R6 stx repeat");
        // R2/R3: non-shared flag
        op(1, 2'd0, 32'h200, 0, 2'd2, 0, 0, "R2 ldx nonshared");
        op(1, 2'd1, 32'h200, 0, 2'd2, 0, 1, "R3 stx nonshared ok");
        op(1, 2'd1, 32'h200, 0, 2'd2, 1, 0, "R3 flag cleared");
        // R7: granule match across sizes
        op(2, 2'd0, 32'h300, 1, 2'd3, 0, 0, "R7 ldx dbl");
        op(2, 2'd1, 32'h305, 1, 2'd0, 0, 1, "R7 stx byte in granule");
        op(2, 2'd0, 32'h310, 0, 2'd1, 0, 0, "R7 ldx half");
        op(2, 2'd1, 32'h316, 0, 2'd1, 0, 1, "R7 stx half in granule");
        // R6: mismatched address fails and clears
        op(2, 2'd0, 32'h400, 0, 2'd2, 0, 0, "R6 ldx");
        op(2, 2'd1, 32'h408, 0, 2'd2, 1, 0, "R6 stx other granule");
        op(2, 2'd1, 32'h400, 0, 2'd2, 1, 0, "R6 cleared by mismatch");
        // R1: a newer reservation replaces the older one
        op(3, 2'd0, 32'h500, 1, 2'd2, 0, 0, "R1 first");
        op(3, 2'd0, 32'h600, 1, 2'd2, 0, 0, "R1 second");
        op(3, 2'd1, 32'h500, 1, 2'd2, 1, 0, "R1 old dropped");
        // R8: competitor locked out
        op(0, 2'd0, 32'h700, 1, 2'd2, 0, 0, "R8 cpu0 ldx");
        op(1, 2'd0, 32'h700, 1, 2'd2, 0, 0, "R8 cpu1 ldx");
        op(1, 2'd1, 32'h704, 1, 2'd2, 0, 1, "R8 cpu1 wins");
        op(0, 2'd1, 32'h700, 1, 2'd2, 1, 0, "R8 cpu0 locked out");
        op(2, 2'd0, 32'h800, 1, 2'd2, 0, 0, "R8 ldx");
        op(3, 2'd2, 32'h804, 1, 2'd2, 0, 1, "R8 shared store");
        op(2, 2'd1, 32'h800, 1, 2'd2, 1, 0, "R8 lost to store");
        op(2, 2'd0, 32'h900, 1, 2'd2, 0, 0, "R8 ldx");
        op(3, 2'd2, 32'h900, 0, 2'd2, 0, 1, "R8 nonshared store");
        op(2, 2'd1, 32'h900, 1, 2'd2, 0, 1, "R8 survives nonshared store");
        // R9: clear
        op(1, 2'd0, 32'hA00, 1, 2'd2, 0, 0, "R9 ldx");
        op(1, 2'd3, 32'h0, 0, 2'd0, 0, 0, "R9 clear");
        op(1, 2'd1, 32'hA00, 1, 2'd2, 1, 0, "R9 stx after clear");
        // R10: simultaneous requests, lowest ID first
        p_v[2] = 1; p_k[2] = 2'd0; p_a[2] = 32'hB00; p_sh[2] = 1; p_s[2] = 2'd2;
        p_v[0] = 1; p_k[0] = 2'd0; p_a[0] = 32'hC00; p_sh[0] = 1; p_s[0] = 2'd2;
        drive();
        step();
        chk(resp_id == 2'd0, "R10 priority first", resp_id, 0);
        step();
        chk(resp_id == 2'd2, "R10 priority second", resp_id, 2);
        step();
        // R9: reset in mid-sequence
        op(3, 2'd0, 32'hD00, 1, 2'd2, 0, 0, "R9 ldx before reset");
        do_reset();
        op(3, 2'd1, 32'hD00, 1, 2'd2, 1, 0, "R9 stx after reset");

        // random traffic against the reference model
        for (int it = 0; it < 4000; it++) begin
            for (int c = 0; c < NC; c++) begin
                if (!p_v[c] && ($urandom % 3 == 0)) begin
                    int r = $urandom % 8;
                    p_v[c]  = 1;
                    p_k[c]  = (r < 3) ? 2'd0 : (r < 6) ? 2'd1 : (r == 6) ? 2'd2 : 2'd3;
                    p_a[c]  = 32'h1000 + (($urandom % 4) << 3) + ($urandom % 8);
                    p_sh[c] = ($urandom % 4) != 0;
                    p_s[c]  = 2'($urandom % 4);
                end
            end
            drive();
            step();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule